// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a processor access to a bank of registers that live in a slow, always-on domain. The processor never addresses those registers directly. It first loads three staging registers on a small memory-mapped slave port: a mode word, a target address and a data word. It then writes a start bit in a control register. The bridge raises a request on a downstream register port and keeps it up, with stable fields, until the far side returns a single-cycle acknowledge.

The mode word decides the direction. Its lowest bit selects a write, and the nibble above bit 3 gives the byte enables. The value 0x00 therefore means a read, and 0xf1 means a full-word write. While the transaction runs, the control register reads as 1 and the staging registers refuse updates. Once the acknowledge arrives, the control register reads as 0 again. For a read, the returned word is then waiting in the data register.

Host offsets are byte addresses with fixed meaning: control at 0x0, mode at 0x4, target address at 0x8, data at 0xc.

Top module: `ibr_top`

## Requirements
- R1: After reset, every staging register and the control register read 0 and no downstream request is raised.
- R2: A host write to offset 0x0 with bit 0 set, while idle, makes the control register read 1 and raises the downstream request from the following cycle.
- R3: The request stays up with unchanged address, direction, byte enables and write data until the acknowledge cycle. It is low, and the control register reads 0, from the cycle after the acknowledge.
- R4: When mode bit 0 is 0, the transaction is a read. The direction output is low, and the data register holds the acknowledged read word once the control register reads 0.
- R5: When mode bit 0 is 1, the transaction is a write. The direction output is high, the address output equals the low address bits of the staging address register, and the data register keeps its value through the acknowledge.
- R6: The byte enable output equals mode bits 7:4, with bit 4 governing byte lane 0 (bits 7:0). Each write-data byte lane carries the data register byte when its enable is set and zero otherwise.
- R7: Host writes to the mode, address or data register while a transaction is in progress leave that register unchanged.
- R8: Writing the start bit while a transaction is in progress has no effect: exactly one request is served, and none follows the acknowledge.
- R9: Reading back a staging register returns the stored value. The mode register keeps its low 8 bits and the address register keeps its low AW bits, both zero-extended; the data register keeps all DW bits.
- R10: A write to offset 0x0 with bit 0 clear starts nothing. A write to an offset whose two low bits are not zero changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 4 | Host byte offset |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, combinational from the selected register |
| dn_req | output | 1 | Downstream request, held until acknowledge |
| dn_wr | output | 1 | Downstream transaction is a write |
| dn_addr | output | AW | Downstream register address |
| dn_be | output | DW/8 | Downstream byte enables |
| dn_wdata | output | DW | Downstream write data, disabled lanes zeroed |
| dn_ack | input | 1 | Single-cycle downstream acknowledge |
| dn_rdata | input | DW | Read data, valid with acknowledge |

## Verification
The bench builds the bridge with DW = 32 and AW = 12. This narrow address width means that the upper bits of a full-width host address write are visibly dropped on readback and on the downstream address. It sweeps all sixteen byte-enable patterns in write mode and a set of reads with distinct words. Each transaction uses an acknowledge delay from zero to three cycles. Every transaction that waits two cycles or more also carries host writes and a repeated start bit into the busy window, where they must have no effect.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    // Word slots of the host register window (byte offset bits 3:2)
    localparam logic [1:0] SLOT_CTRL = 2'd0;
    localparam logic [1:0] SLOT_MODE = 2'd1;
    localparam logic [1:0] SLOT_ADDR = 2'd2;
    localparam logic [1:0] SLOT_DATA = 2'd3;

    // Mode word layout
    localparam int MODE_WR_BIT = 0;
    localparam int MODE_BE_LSB = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    // One-hot write strobes for the staging registers
    typedef struct packed {
        logic ctrl;
        logic mode;
        logic addr;
        logic data;
    } stage_we_t;

    function automatic stage_we_t decode_we(input logic sel, input logic wr,
                                            input logic [3:0] ofs);
        stage_we_t w;
        logic hit;
        hit    = sel && wr && (ofs[1:0] == 2'b00);
        w.ctrl = hit && (ofs[3:2] == SLOT_CTRL);
        w.mode = hit && (ofs[3:2] == SLOT_MODE);
        w.addr = hit && (ofs[3:2] == SLOT_ADDR);
        w.data = hit && (ofs[3:2] == SLOT_DATA);
        return w;
    endfunction

endpackage

// File: rtl/ibr_sequencer.sv
module ibr_sequencer
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic busy
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_BUSY;
                ST_BUSY: if (ack)   state_q <= ST_IDLE;
                default:            state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_BUSY);

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack) |=> busy);
    // R3
    release_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ack) |=> !busy);
endmodule

// File: rtl/ibr_stage_regs.sv
module ibr_stage_regs
    import ibr_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 16,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_we_t         we,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    input  logic              capture,
    input  logic [DW-1:0]     cap_data,
    output logic [MODE_W-1:0] mode_q,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     data_q
);
    logic open;
    assign open = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (open && we.mode) mode_q <= wdata[MODE_W-1:0];
            if (open && we.addr) addr_q <= wdata[AW-1:0];
            if (capture)
                data_q <= cap_data;
            else if (open && we.data)
                data_q <= wdata;
        end
    end

    // R7
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !capture) |=> ($stable(mode_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/ibr_lane_mask.sv
module ibr_lane_mask #(
    parameter int DW    = 32,
    parameter int LANES = DW / 8
) (
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*8 +: 8] = be[i] ? din[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/ibr_top.sv
module ibr_top
    import ibr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic [3:0]        h_addr,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    output logic              dn_req,
    output logic              dn_wr,
    output logic [AW-1:0]     dn_addr,
    output logic [DW/8-1:0]   dn_be,
    output logic [DW-1:0]     dn_wdata,
    input  logic              dn_ack,
    input  logic [DW-1:0]     dn_rdata
);
    localparam int LANES  = DW / 8;
    localparam int MODE_W = MODE_BE_LSB + LANES;

    stage_we_t         we;
    logic              busy;
    logic              start;
    logic              capture;
    logic [MODE_W-1:0] mode_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     data_q;

    assign we      = decode_we(h_sel, h_wr, h_addr);
    assign start   = we.ctrl && h_wdata[0];
    assign capture = busy && dn_ack && !mode_q[MODE_WR_BIT];

    ibr_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ack   (dn_ack),
        .busy  (busy)
    );

    ibr_stage_regs #(.DW(DW), .AW(AW), .MODE_W(MODE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .wdata    (h_wdata),
        .busy     (busy),
        .capture  (capture),
        .cap_data (dn_rdata),
        .mode_q   (mode_q),
        .addr_q   (addr_q),
        .data_q   (data_q)
    );

    ibr_lane_mask #(.DW(DW), .LANES(LANES)) u_mask (
        .be   (dn_be),
        .din  (data_q),
        .dout (dn_wdata)
    );

    assign dn_req  = busy;
    assign dn_wr   = mode_q[MODE_WR_BIT];
    assign dn_addr = addr_q;
    assign dn_be   = mode_q[MODE_BE_LSB +: LANES];

    always_comb begin
        h_rdata = '0;
        if (h_sel && !h_wr) begin
            case (h_addr[3:2])
                SLOT_CTRL: h_rdata[0]          = busy;
                SLOT_MODE: h_rdata[MODE_W-1:0] = mode_q;
                SLOT_ADDR: h_rdata[AW-1:0]     = addr_q;
                default:   h_rdata             = data_q;
            endcase
        end
    end

    // R3
    req_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_wr)
                                 && $stable(dn_be) && $stable(dn_wdata)));
    // R4
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_ack && !dn_wr) |=> (data_q == $past(dn_rdata)));
    // R5
    write_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_ack && dn_wr) |=> $stable(data_q));
    // R10
    clear_bit_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!dn_req && h_sel && h_wr && !h_wdata[0]
         && !(h_addr[3:2] == SLOT_CTRL && h_addr[1:0] == 2'b00 && h_wdata[0])) |=> !dn_req);
endmodule

// File: tb/ibr_top_bench.sv
module ibr_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            h_sel = 1'b0;
    logic            h_wr = 1'b0;
    logic [3:0]      h_addr = '0;
    logic [DW-1:0]   h_wdata = '0;
    logic [DW-1:0]   h_rdata;
    logic            dn_req;
    logic            dn_wr;
    logic [AW-1:0]   dn_addr;
    logic [DW/8-1:0] dn_be;
    logic [DW-1:0]   dn_wdata;
    logic            dn_ack = 1'b0;
    logic [DW-1:0]   dn_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibr_top #(.DW(DW), .AW(AW)) u_ibr_top (
        .clk(clk), .rst(rst),
        .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .dn_req(dn_req), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_be(dn_be),
        .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic hw(input logic [3:0] ofs, input logic [31:0] d);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = ofs; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
    endtask

    task automatic hr(input logic [3:0] ofs, output logic [31:0] d);
        h_sel = 1'b1; h_wr = 1'b0; h_addr = ofs;
        #1;
        d = h_rdata;
        h_sel = 1'b0;
    endtask

    function automatic logic [31:0] lane_exp(input logic [3:0] be, input logic [31:0] d);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
        return r;
    endfunction

    task automatic run_txn(input logic [7:0] mode, input logic [31:0] addr,
                           input logic [31:0] data, input int delay,
                           input logic [31:0] rdval);
        logic [31:0] v;
        logic [31:0] exp_addr;
        logic        is_wr;
        exp_addr = addr & 32'h0000_0FFF;
        is_wr    = mode[0];
        hw(4'h4, {24'hABCDEF, mode});
        hw(4'h8, addr);
        hw(4'hC, data);
        hw(4'h0, 32'h1);
        hr(4'h0, v);               check("R2 ctrl busy", v, 32'h1);
        check("R2 req up", {31'b0, dn_req}, 32'h1);
        check(is_wr ? "R5 dir write" : "R4 dir read", {31'b0, dn_wr}, {31'b0, is_wr});
        check("R5 dn_addr", {20'b0, dn_addr}, exp_addr);
        check("R6 dn_be", {28'b0, dn_be}, {28'b0, mode[7:4]});
        if (is_wr) check("R6 lane data", dn_wdata, lane_exp(mode[7:4], data));
        if (delay >= 2) begin
            hw(4'h8, ~addr);
            hw(4'h0, 32'h1);
            repeat (delay - 2) @(negedge clk);
            check("R3 req held", {31'b0, dn_req}, 32'h1);
            check("R3 addr held", {20'b0, dn_addr}, exp_addr);
        end else begin
            repeat (delay) @(negedge clk);
        end
        dn_ack = 1'b1; dn_rdata = rdval;
        @(negedge clk);
        dn_ack = 1'b0; dn_rdata = 32'hDEAD_BEEF;
        hr(4'h0, v);               check("R3 ctrl idle", v, 32'h0);
        check("R3 req low", {31'b0, dn_req}, 32'h0);
        hr(4'hC, v);
        if (is_wr) check("R5 data kept", v, data);
        else       check("R4 read data", v, rdval);
        hr(4'h8, v);               check("R7 addr unchanged", v, exp_addr);
        repeat (2) @(negedge clk);
        check("R8 single request", {31'b0, dn_req}, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            hr(4'(s * 4), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 no req", {31'b0, dn_req}, 32'h0);

        // R9 readback widths
        hw(4'h4, 32'h1234_56F1); hr(4'h4, v); check("R9 mode readback", v, 32'hF1);
        hw(4'h8, 32'hFFFF_FABC); hr(4'h8, v); check("R9 addr readback", v, 32'hABC);
        hw(4'hC, 32'hCAFE_F00D); hr(4'hC, v); check("R9 data readback", v, 32'hCAFE_F00D);

        // R10 clear bit and misaligned offsets
        hw(4'h0, 32'hFFFF_FFFE);
        check("R10 no start", {31'b0, dn_req}, 32'h0);
        hw(4'hD, 32'h1111_1111); hr(4'hC, v); check("R10 misaligned data", v, 32'hCAFE_F00D);
        hw(4'h1, 32'h1);
        check("R10 misaligned ctrl", {31'b0, dn_req}, 32'h0);

        // R5 R6 write sweep over every byte-enable pattern
        for (int m = 0; m < 16; m++)
            run_txn({4'(m), 4'b0001}, 32'h0005_0000 + m * 4,
                    32'hA1B2_C3D4 ^ (m * 32'h0101_0101), m % 4, 32'h0);

        // R4 read sweep
        for (int k = 0; k < 8; k++)
            run_txn(8'h00, 32'hF000_0100 + k * 8, 32'h7777_7777, k % 4,
                    32'h5A00_0000 ^ (k * 32'h0103_0507));
        // read with enable bits set is still a read
        run_txn(8'h40, 32'h3FC, 32'h0, 2, 32'h0BAD_CAFE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule